// File: doc/BRIEF.md
# Rule-Based Address Map Decoder

This block turns a request address into the number of the output port that should serve it. It compares the address against a table of rules. Each rule names an output port and gives the range that the port owns, as a lower and an upper address. Every rule gets its own comparator, and the rules are checked in parallel. A priority stage then picks one rule. The result is captured in a register, so the port number, a hit flag and a decode-error flag appear one clock cycle after the address and the table are presented.

The lower address of a range belongs to the range and the upper address does not. Any number of rules may point at the same port, so one port can own several separate windows. If no rule matches, the request either counts as a decode error, which an error responder downstream would answer, or goes to a fallback port. The fallback is used only when the caller enables it and supplies a valid fallback port number. The number of rules, the number of ports and the address and index widths are parameters.

Top module: `addr_rule_decoder`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next outputs are `tgt_idx_o = 0`, `hit_o = 0` and `decerr_o = 0`.
- R2: A rule matches when `start <= addr < end`, using unsigned comparison. A match drives `hit_o = 1`, `decerr_o = 0` and `tgt_idx_o` equal to that rule's port number. The outputs appear one clock cycle after the inputs.
- R3: The end address itself is not matched by a rule. A rule whose start equals its end matches no address.
- R4: Two or more rules may carry the same port number, and each of their ranges decodes to that port.
- R5: When several rules match, the rule with the highest table position decides `tgt_idx_o`.
- R6: A rule whose port number is `NUM_PORTS` or more never matches. A lower-placed rule that covers the same address may then decide the result.
- R7: When no rule matches and `dflt_en_i = 0`, the outputs are `decerr_o = 1`, `hit_o = 0` and `tgt_idx_o = 0`.
- R8: When no rule matches, `dflt_en_i = 1` and `dflt_idx_i < NUM_PORTS`, the outputs are `hit_o = 1`, `decerr_o = 0` and `tgt_idx_o = dflt_idx_i`. When a rule does match, the fallback is ignored.
- R9: When no rule matches, `dflt_en_i = 1` and `dflt_idx_i >= NUM_PORTS`, the result is a decode error, as in R7.
- R10: `hit_o` and `decerr_o` are never high together. Whenever `hit_o` is high, `tgt_idx_o < NUM_PORTS`.
- R11: A rule whose start is greater than its end matches no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | Address to decode |
| rule_port_i | input | NUM_RULES x IDX_W | Port number of each rule |
| rule_start_i | input | NUM_RULES x ADDR_W | Lower address of each rule, included in the range |
| rule_end_i | input | NUM_RULES x ADDR_W | Upper address of each rule, excluded from the range |
| dflt_en_i | input | 1 | Send unmatched addresses to the fallback port |
| dflt_idx_i | input | IDX_W | Fallback port number |
| tgt_idx_o | output | IDX_W | Selected port number, registered |
| hit_o | output | 1 | A port was selected, registered |
| decerr_o | output | 1 | Decode error, registered |

## Verification
The hardest case to reach from the ports is an address covered by several rules at once, where the highest-placed of those rules carries an illegal port number. Here the priority must fall back to the next legal rule rather than to the fallback port or to an error. The bench builds a rule table with an overlapping window and checks the plain highest-wins outcome. It then reprograms that overlapping rule with an out-of-range port number, and separately with empty and inverted ranges, and checks again. A reference loop over the rule table also checks many addresses placed at one below the start, the start, one below the end and the end of each rule, with the fallback switched on and off.

// File: rtl/addr_rule_pkg.sv
package addr_rule_pkg;

  // Outcome of one decode before it is registered
  typedef enum logic [1:0] {
    DEC_MISS = 2'd0,
    DEC_RULE = 2'd1,
    DEC_DFLT = 2'd2
  } dec_kind_e;

endpackage

// File: rtl/addr_rule_cmp.sv
// One comparator per rule: half-open range test plus a port-range check.
module addr_rule_cmp #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned IDX_W     = 3,
  parameter int unsigned NUM_PORTS = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] hi_i,
  input  logic [IDX_W-1:0]  port_i,
  output logic              match_o
);

  localparam int unsigned LIM_W = IDX_W + 1;
  localparam logic [LIM_W-1:0] PORT_LIM = LIM_W'(NUM_PORTS);

  logic above_lo;
  logic below_hi;
  logic port_ok;

  always_comb begin
    above_lo = (addr_i >= lo_i);
    below_hi = (addr_i < hi_i);
    port_ok  = ({1'b0, port_i} < PORT_LIM);
    match_o  = above_lo && below_hi && port_ok;
  end

endmodule

// File: rtl/addr_rule_pick.sv
// Priority stage: the highest table position among the matching rules wins.
module addr_rule_pick #(
  parameter int unsigned NUM_RULES = 4,
  parameter int unsigned IDX_W     = 3
) (
  input  logic [NUM_RULES-1:0]            match_i,
  input  logic [NUM_RULES-1:0][IDX_W-1:0] port_i,
  output logic                            any_o,
  output logic [IDX_W-1:0]                idx_o
);

  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int r = 0; r < NUM_RULES; r++) begin
      if (match_i[r]) begin
        any_o = 1'b1;
        idx_o = port_i[r];
      end
    end
  end

endmodule

// File: rtl/addr_rule_decoder.sv
// Rule table address decoder with an optional fallback port; outputs registered.
module addr_rule_decoder
  import addr_rule_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned NUM_RULES = 4,
  parameter int unsigned NUM_PORTS = 5,
  parameter int unsigned IDX_W     = 3
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [NUM_RULES-1:0][IDX_W-1:0]  rule_port_i,
  input  logic [NUM_RULES-1:0][ADDR_W-1:0] rule_start_i,
  input  logic [NUM_RULES-1:0][ADDR_W-1:0] rule_end_i,
  input  logic                             dflt_en_i,
  input  logic [IDX_W-1:0]                 dflt_idx_i,
  output logic [IDX_W-1:0]                 tgt_idx_o,
  output logic                             hit_o,
  output logic                             decerr_o
);

  localparam int unsigned LIM_W = IDX_W + 1;
  localparam logic [LIM_W-1:0] PORT_LIM = LIM_W'(NUM_PORTS);

  logic [NUM_RULES-1:0] rule_match;
  logic                 any_match;
  logic [IDX_W-1:0]     rule_idx;
  logic                 dflt_ok;
  dec_kind_e            kind;
  logic [IDX_W-1:0]     next_idx;

  for (genvar g = 0; g < NUM_RULES; g++) begin : g_rule
    addr_rule_cmp #(
      .ADDR_W    (ADDR_W),
      .IDX_W     (IDX_W),
      .NUM_PORTS (NUM_PORTS)
    ) cmp_i (
      .addr_i  (addr_i),
      .lo_i    (rule_start_i[g]),
      .hi_i    (rule_end_i[g]),
      .port_i  (rule_port_i[g]),
      .match_o (rule_match[g])
    );
  end

  addr_rule_pick #(
    .NUM_RULES (NUM_RULES),
    .IDX_W     (IDX_W)
  ) pick_i (
    .match_i (rule_match),
    .port_i  (rule_port_i),
    .any_o   (any_match),
    .idx_o   (rule_idx)
  );

  always_comb begin
    dflt_ok = dflt_en_i && ({1'b0, dflt_idx_i} < PORT_LIM);
    if (any_match)    kind = DEC_RULE;
    else if (dflt_ok) kind = DEC_DFLT;
    else              kind = DEC_MISS;
    case (kind)
      DEC_RULE: next_idx = rule_idx;
      DEC_DFLT: next_idx = dflt_idx_i;
      default:  next_idx = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_idx_o <= '0;
      hit_o     <= 1'b0;
      decerr_o  <= 1'b0;
    end else begin
      tgt_idx_o <= next_idx;
      hit_o     <= (kind != DEC_MISS);
      decerr_o  <= (kind == DEC_MISS);
    end
  end

endmodule

// File: rtl/addr_rule_decoder_chk.sv
module addr_rule_decoder_chk #(
  parameter int unsigned NUM_PORTS = 5,
  parameter int unsigned IDX_W     = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             dflt_en_i,
  input logic [IDX_W-1:0] dflt_idx_i,
  input logic [IDX_W-1:0] tgt_idx_o,
  input logic             hit_o,
  input logic             decerr_o
);

  localparam int unsigned LIM_W = IDX_W + 1;
  localparam logic [LIM_W-1:0] PORT_LIM = LIM_W'(NUM_PORTS);

  assert_reset_zero_R1: assert property (@(posedge clk)
    $past(rst) |-> (!hit_o && !decerr_o && tgt_idx_o == '0));

  assert_hit_err_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(hit_o && decerr_o));

  assert_hit_idx_range_R10: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> ({1'b0, tgt_idx_o} < PORT_LIM));

  assert_err_idx_zero_R7: assert property (@(posedge clk) disable iff (rst)
    decerr_o |-> (tgt_idx_o == '0));

  assert_dflt_no_err_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dflt_en_i) && ({1'b0, $past(dflt_idx_i)} < PORT_LIM))
      |-> !decerr_o);

endmodule

bind addr_rule_decoder addr_rule_decoder_chk #(
  .NUM_PORTS (NUM_PORTS),
  .IDX_W     (IDX_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .dflt_en_i  (dflt_en_i),
  .dflt_idx_i (dflt_idx_i),
  .tgt_idx_o  (tgt_idx_o),
  .hit_o      (hit_o),
  .decerr_o   (decerr_o)
);

// File: tb/addr_rule_decoder_tb_top.sv
`timescale 1ns/1ps
module addr_rule_decoder_tb_top;

  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned NUM_RULES = 4;
  localparam int unsigned NUM_PORTS = 5;
  localparam int unsigned IDX_W     = 3;

  logic                             clk = 1'b0;
  logic                             rst = 1'b1;
  logic [ADDR_W-1:0]                addr_i = '0;
  logic [NUM_RULES-1:0][IDX_W-1:0]  rule_port_i;
  logic [NUM_RULES-1:0][ADDR_W-1:0] rule_start_i;
  logic [NUM_RULES-1:0][ADDR_W-1:0] rule_end_i;
  logic                             dflt_en_i = 1'b0;
  logic [IDX_W-1:0]                 dflt_idx_i = '0;
  logic [IDX_W-1:0]                 tgt_idx_o;
  logic                             hit_o;
  logic                             decerr_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  addr_rule_decoder #(
    .ADDR_W (ADDR_W), .NUM_RULES (NUM_RULES),
    .NUM_PORTS (NUM_PORTS), .IDX_W (IDX_W)
  ) dut_i (
    .clk (clk), .rst (rst), .addr_i (addr_i),
    .rule_port_i (rule_port_i), .rule_start_i (rule_start_i), .rule_end_i (rule_end_i),
    .dflt_en_i (dflt_en_i), .dflt_idx_i (dflt_idx_i),
    .tgt_idx_o (tgt_idx_o), .hit_o (hit_o), .decerr_o (decerr_o)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic        den;
    logic [2:0]  didx;
    logic        ehit;
    logic        eerr;
    logic [2:0]  eidx;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 15;
  // Rules: 0 -> port1 [1000,2000), 1 -> port3 [3000,4000),
  //        2 -> port1 [5000,5800), 3 -> port2 [1800,1900)
  localparam vec_t VECS [NV] = '{
    '{32'h1000, 1'b0, 3'd0, 1'b1, 1'b0, 3'd1, 8'd2},  // R2 start
    '{32'h0FFF, 1'b0, 3'd0, 1'b0, 1'b1, 3'd0, 8'd3},  // R3 start-1
    '{32'h1FFF, 1'b0, 3'd0, 1'b1, 1'b0, 3'd1, 8'd2},  // R2 end-1
    '{32'h2000, 1'b0, 3'd0, 1'b0, 1'b1, 3'd0, 8'd3},  // R3 end excluded
    '{32'h1800, 1'b0, 3'd0, 1'b1, 1'b0, 3'd2, 8'd5},  // R5 overlap start
    '{32'h18FF, 1'b0, 3'd0, 1'b1, 1'b0, 3'd2, 8'd5},  // R5 overlap end-1
    '{32'h1900, 1'b0, 3'd0, 1'b1, 1'b0, 3'd1, 8'd5},  // R5 past overlap
    '{32'h3ABC, 1'b0, 3'd0, 1'b1, 1'b0, 3'd3, 8'd2},  // R2 middle
    '{32'h5000, 1'b0, 3'd0, 1'b1, 1'b0, 3'd1, 8'd4},  // R4 second window
    '{32'h57FF, 1'b0, 3'd0, 1'b1, 1'b0, 3'd1, 8'd4},  // R4 second window end-1
    '{32'h5800, 1'b0, 3'd0, 1'b0, 1'b1, 3'd0, 8'd3},  // R3 second window end
    '{32'h9000, 1'b1, 3'd4, 1'b1, 1'b0, 3'd4, 8'd8},  // R8 fallback used
    '{32'h9000, 1'b0, 3'd4, 1'b0, 1'b1, 3'd0, 8'd7},  // R7 fallback off
    '{32'h1234, 1'b1, 3'd0, 1'b1, 1'b0, 3'd1, 8'd8},  // R8 match beats fallback
    '{32'h9000, 1'b1, 3'd6, 1'b0, 1'b1, 3'd0, 8'd9}   // R9 illegal fallback
  };

  task automatic load_rules();
    rule_port_i[0] = 3'd1; rule_start_i[0] = 32'h1000; rule_end_i[0] = 32'h2000;
    rule_port_i[1] = 3'd3; rule_start_i[1] = 32'h3000; rule_end_i[1] = 32'h4000;
    rule_port_i[2] = 3'd1; rule_start_i[2] = 32'h5000; rule_end_i[2] = 32'h5800;
    rule_port_i[3] = 3'd2; rule_start_i[3] = 32'h1800; rule_end_i[3] = 32'h1900;
  endtask

  task automatic check(input int req, input logic ehit, input logic eerr,
                       input logic [IDX_W-1:0] eidx);
    checks++;
    if (hit_o !== ehit || decerr_o !== eerr || tgt_idx_o !== eidx) begin
      errors++;
      $display("FAIL R%0d addr=%h: hit=%b err=%b idx=%0d, expected hit=%b err=%b idx=%0d",
               req, addr_i, hit_o, decerr_o, tgt_idx_o, ehit, eerr, eidx);
    end
  endtask

  // Drive on a falling edge, let one rising edge register, sample at the next falling edge.
  task automatic run(input logic [ADDR_W-1:0] a, input logic den, input logic [IDX_W-1:0] di,
                     input int req, input logic ehit, input logic eerr,
                     input logic [IDX_W-1:0] eidx);
    @(negedge clk);
    addr_i = a; dflt_en_i = den; dflt_idx_i = di;
    @(negedge clk);
    check(req, ehit, eerr, eidx);
  endtask

  // Independent reference: last legal matching rule, else fallback, else error.
  task automatic ref_decode(input logic [ADDR_W-1:0] a, input logic den,
                            input logic [IDX_W-1:0] di, output logic h, output logic e,
                            output logic [IDX_W-1:0] ix);
    h = 1'b0; e = 1'b0; ix = '0;
    for (int r = 0; r < NUM_RULES; r++) begin
      if (a >= rule_start_i[r] && a < rule_end_i[r] && int'(rule_port_i[r]) < NUM_PORTS) begin
        h = 1'b1; ix = rule_port_i[r];
      end
    end
    if (!h) begin
      if (den && int'(di) < NUM_PORTS) begin h = 1'b1; ix = di; end
      else e = 1'b1;
    end
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    logic eh, ee;
    logic [IDX_W-1:0] ei;
    load_rules();
    addr_i = 32'h1000;
    // R1: reset held with a hitting address still yields zero outputs
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(1, 1'b0, 1'b0, 3'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++)
      run(VECS[i].addr, VECS[i].den, VECS[i].didx, int'(VECS[i].req),
          VECS[i].ehit, VECS[i].eerr, VECS[i].eidx);

    // R6: top overlapping rule given port 7 -> rule 0 (port 1) decides
    rule_port_i[3] = 3'd7;
    run(32'h1800, 1'b0, 3'd0, 6, 1'b1, 1'b0, 3'd1);
    // R6: illegal port 5 alone never hits, fallback takes over
    rule_port_i[3] = 3'd5; rule_start_i[3] = 32'hA000; rule_end_i[3] = 32'hB000;
    run(32'hA800, 1'b1, 3'd0, 6, 1'b1, 1'b0, 3'd0);
    // R11: inverted range matches nothing
    rule_start_i[1] = 32'h4000; rule_end_i[1] = 32'h3000;
    run(32'h3500, 1'b0, 3'd0, 11, 1'b0, 1'b1, 3'd0);
    // R3: empty range start == end
    rule_start_i[1] = 32'h3000; rule_end_i[1] = 32'h3000;
    run(32'h3000, 1'b0, 3'd0, 3, 1'b0, 1'b1, 3'd0);

    // R1: reset asserted mid-run clears registered outputs
    @(negedge clk); rst = 1'b1; addr_i = 32'h1000;
    @(negedge clk); check(1, 1'b0, 1'b0, 3'd0);
    rst = 1'b0;

    // Reference sweep at rule boundaries (R2 R3 R5 R10)
    load_rules();
    seed = 32'h1ACE_0001;
    for (int i = 0; i < 400; i++) begin
      logic [ADDR_W-1:0] a;
      logic den;
      logic [IDX_W-1:0] di;
      int r;
      seed = seed * 32'd1103515245 + 32'd12345;
      r = int'(seed[17:16]);
      case (seed[20:18])
        3'd0: a = rule_start_i[r] - 1;
        3'd1: a = rule_start_i[r];
        3'd2: a = rule_end_i[r] - 1;
        3'd3: a = rule_end_i[r];
        default: a = {16'h0, seed[31:16]};
      endcase
      den = seed[9];
      di  = seed[12:10];
      ref_decode(a, den, di, eh, ee, ei);
      run(a, den, di, 10, eh, ee, ei);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule